// File: doc/BRIEF.md
# Interrupt Master and Individual Enable Unit

This block keeps the interrupt enable state of a small 8-bit CPU core and decides which pending request the core may take next. A 32-bit enable word is reached through a byte-wide register port over four consecutive addresses. Bit 0 of the lowest byte is the master enable. Bits 4 to 25 are the per-source enables for maskable sources 4 to 25. Any read-modify-write bit operation from the core therefore round-trips through ordinary byte reads and writes.

The core drives a few control strobes: one that sets the master enable, one that clears it, an accept strobe and a return strobe. The accept strobe presents the current master enable for saving and then clears it. The return strobe reloads the master enable from the saved value that the core hands back. Three non-maskable sources, numbered 0 to 2, ignore every enable bit. Maskable sources need the master enable and their own bit. A purely combinational arbiter reports a valid flag and the index of the winning source.

Top module: `intr_enable_unit`

## Requirements
- R1: After reset the master enable and every individual enable are 0, every enable byte reads 0x00, and no maskable request produces a valid output.
- R2: A maskable request on source j (4 to 25) makes req_valid 1 only when the master enable is 1 and enable bit j is 1.
- R3: Any non-maskable request (nmi_req bit 0 software, bit 1 undefined-instruction trap, bit 2 watchdog) makes req_valid 1 whatever the enable word holds.
- R4: When several requests are eligible, req_idx names the lowest-numbered pending non-maskable source (index 0 to 2) if there is one, and otherwise the lowest-numbered eligible maskable source (index equal to its enable bit position).
- R5: men_save always shows the current master enable, and in the cycle after an accept strobe the master enable is 0.
- R6: A return strobe without an accept loads the master enable from men_restore in the next cycle.
- R7: An enable strobe sets the master enable to 1 and a disable strobe clears it to 0. If both come in the same cycle, the disable wins.
- R8: Byte k of the enable word (bits 8k to 8k+7) sits at address 0x3A+k for k = 0 to 3, and the master enable is bit 0 of address 0x3A. A write followed by a read of the same byte returns the written implemented bits. Any other address reads 0x00 and a write to it changes nothing.
- R9: Bits 1 to 3 and bits 26 to 31 of the enable word are not implemented: they always read 0 and ignore writes.
- R10: For the master enable, same-cycle events take effect in this order: accept, then return, then disable, then enable, then a register write to bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 8 | Register write data |
| reg_we | input | 1 | Register write strobe |
| reg_rdata | output | 8 | Register read data for reg_addr (combinational) |
| men_set | input | 1 | Enable-interrupts strobe |
| men_clr | input | 1 | Disable-interrupts strobe |
| irq_accept | input | 1 | Core accepts the presented request |
| irq_return | input | 1 | Return-from-interrupt strobe |
| men_restore | input | 1 | Saved master enable handed back on return |
| men_save | output | 1 | Current master enable, for saving on accept |
| nmi_req | input | 3 | Non-maskable requests |
| mask_req | input | 32 | Maskable requests, bit j for source j |
| req_valid | output | 1 | An eligible request exists |
| req_idx | output | 5 | Index of the winning source |

## Verification
The bench builds the block with its default parameters: four enable bytes at base address 0x3A, maskable sources 4 to 25, three non-maskable sources. With these values every byte address, both unimplemented bit ranges, and addresses just below and above the window are within reach of random accesses. Random traffic mixes the control strobes so that the priority chain on the master enable is exercised, including same-cycle collisions with register writes. Requests cover many patterns, so the arbiter sees overlapping non-maskable and maskable requests both with the master enable on and with it off.

// File: rtl/ieu_pkg.sv
package ieu_pkg;
    localparam int unsigned IEU_BYTES = 4;
    localparam int unsigned IEU_W     = IEU_BYTES * 8;

    typedef enum logic [2:0] {
        MEN_HOLD,
        MEN_WRITE,
        MEN_SET,
        MEN_CLR,
        MEN_RESTORE,
        MEN_ACCEPT
    } men_src_e;

    typedef struct packed {
        logic             men;
        logic [IEU_W-1:0] ef;
    } ieu_state_t;
endpackage

// File: rtl/ieu_regfile.sv
module ieu_regfile
    import ieu_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned BASE   = 8'h3A,
    parameter int unsigned MSK_LO = 4,
    parameter int unsigned MSK_HI = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    input  logic              reg_we,
    output logic [7:0]        reg_rdata,
    input  logic              men_set,
    input  logic              men_clr,
    input  logic              irq_accept,
    input  logic              irq_return,
    input  logic              men_restore,
    output logic              men_q,
    output logic [IEU_W-1:0]  ef_q
);
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);

    function automatic logic [IEU_W-1:0] impl_mask();
        logic [IEU_W-1:0] m;
        for (int i = 0; i < IEU_W; i++) begin
            m[i] = (i >= MSK_LO) && (i <= MSK_HI);
        end
        return m;
    endfunction

    localparam logic [IEU_W-1:0] IMPL = impl_mask();

    ieu_state_t st_d, st_q;
    men_src_e   src;
    logic [ADDR_W-1:0] off;
    logic [IEU_W-1:0]  full;

    always_comb begin
        st_d = st_q;
        off  = reg_addr - BASE_A;

        // individual flags: byte writes through the mask of real bits
        for (int b = 0; b < IEU_BYTES; b++) begin
            if (reg_we && off == ADDR_W'(b)) begin
                st_d.ef[8*b +: 8] = reg_wdata & IMPL[8*b +: 8];
            end
        end

        // master enable: fixed priority chain
        if (irq_accept)                          src = MEN_ACCEPT;
        else if (irq_return)                     src = MEN_RESTORE;
        else if (men_clr)                        src = MEN_CLR;
        else if (men_set)                        src = MEN_SET;
        else if (reg_we && off == '0)            src = MEN_WRITE;
        else                                     src = MEN_HOLD;

        case (src)
            MEN_ACCEPT:  st_d.men = 1'b0;
            MEN_RESTORE: st_d.men = men_restore;
            MEN_CLR:     st_d.men = 1'b0;
            MEN_SET:     st_d.men = 1'b1;
            MEN_WRITE:   st_d.men = reg_wdata[0];
            default:     st_d.men = st_q.men;
        endcase

        // read path
        full      = st_q.ef;
        full[0]   = st_q.men;
        reg_rdata = 8'h00;
        for (int b = 0; b < IEU_BYTES; b++) begin
            if (off == ADDR_W'(b)) begin
                reg_rdata = full[8*b +: 8];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign men_q = st_q.men;
    assign ef_q  = st_q.ef;
endmodule

// File: rtl/ieu_arbiter.sv
module ieu_arbiter #(
    parameter int unsigned W     = 32,
    parameter int unsigned NMI_N = 3,
    parameter int unsigned IDX_W = 5
) (
    input  logic             men,
    input  logic [W-1:0]     ef,
    input  logic [NMI_N-1:0] nmi_req,
    input  logic [W-1:0]     mask_req,
    output logic             req_valid,
    output logic [IDX_W-1:0] req_idx
);
    logic [W-1:0] elig;
    logic         nmi_any;

    always_comb begin
        elig    = mask_req & ef & {W{men}};
        nmi_any = |nmi_req;
        req_idx = '0;
        if (nmi_any) begin
            for (int i = NMI_N - 1; i >= 0; i--) begin
                if (nmi_req[i]) req_idx = IDX_W'(i);
            end
        end else begin
            for (int j = W - 1; j >= 0; j--) begin
                if (elig[j]) req_idx = IDX_W'(j);
            end
        end
        req_valid = nmi_any | (|elig);
    end
endmodule

// File: rtl/intr_enable_unit.sv
module intr_enable_unit
    import ieu_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned BASE   = 8'h3A,
    parameter int unsigned MSK_LO = 4,
    parameter int unsigned MSK_HI = 25,
    parameter int unsigned NMI_N  = 3,
    parameter int unsigned IDX_W  = $clog2(IEU_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    input  logic              reg_we,
    output logic [7:0]        reg_rdata,
    input  logic              men_set,
    input  logic              men_clr,
    input  logic              irq_accept,
    input  logic              irq_return,
    input  logic              men_restore,
    output logic              men_save,
    input  logic [NMI_N-1:0]  nmi_req,
    input  logic [IEU_W-1:0]  mask_req,
    output logic              req_valid,
    output logic [IDX_W-1:0]  req_idx
);
    logic             men_q;
    logic [IEU_W-1:0] ef_q;

    ieu_regfile #(
        .ADDR_W(ADDR_W), .BASE(BASE), .MSK_LO(MSK_LO), .MSK_HI(MSK_HI)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
        .reg_rdata(reg_rdata),
        .men_set(men_set), .men_clr(men_clr),
        .irq_accept(irq_accept), .irq_return(irq_return),
        .men_restore(men_restore),
        .men_q(men_q), .ef_q(ef_q)
    );

    ieu_arbiter #(
        .W(IEU_W), .NMI_N(NMI_N), .IDX_W(IDX_W)
    ) u_arb (
        .men(men_q), .ef(ef_q),
        .nmi_req(nmi_req), .mask_req(mask_req),
        .req_valid(req_valid), .req_idx(req_idx)
    );

    assign men_save = men_q;
endmodule

// File: rtl/ieu_chk.sv
module ieu_chk #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned BASE   = 8'h3A,
    parameter int unsigned NMI_N  = 3,
    parameter int unsigned IDX_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [7:0]        reg_rdata,
    input logic              men_set,
    input logic              men_clr,
    input logic              irq_accept,
    input logic              irq_return,
    input logic              men_restore,
    input logic              men_save,
    input logic [NMI_N-1:0]  nmi_req,
    input logic              req_valid,
    input logic [IDX_W-1:0]  req_idx
);
    localparam logic [IDX_W-1:0]  NMI_LIM = IDX_W'(NMI_N);
    localparam logic [ADDR_W-1:0] BASE_A  = ADDR_W'(BASE);

    // R5
    a_r5_accept_clears: assert property (@(posedge clk) disable iff (!rst_n)
        irq_accept |=> !men_save);
    // R6
    a_r6_return_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_return && !irq_accept) |=> (men_save == $past(men_restore)));
    // R7
    a_r7_clear_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (men_clr && !irq_accept && !irq_return) |=> !men_save);
    a_r7_set_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (men_set && !men_clr && !irq_accept && !irq_return) |=> men_save);
    // R3
    a_r3_nmi_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (|nmi_req) |-> (req_valid && req_idx < NMI_LIM));
    // R2
    a_r2_master_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!men_save && !(|nmi_req)) |-> !req_valid);
    // R9
    a_r9_low_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == BASE_A) |-> (reg_rdata[3:1] == 3'b000));
endmodule

bind intr_enable_unit ieu_chk #(
    .ADDR_W(ADDR_W), .BASE(BASE), .NMI_N(NMI_N), .IDX_W(IDX_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
    .men_set(men_set), .men_clr(men_clr), .irq_accept(irq_accept),
    .irq_return(irq_return), .men_restore(men_restore), .men_save(men_save),
    .nmi_req(nmi_req), .req_valid(req_valid), .req_idx(req_idx)
);

// File: tb/tb_intr_enable_unit.sv
`timescale 1ns/1ps
module tb_intr_enable_unit;
    localparam logic [31:0] IMPL = 32'h03FF_FFF0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0, reg_wdata = '0, reg_rdata;
    logic        reg_we = 0, men_set = 0, men_clr = 0;
    logic        irq_accept = 0, irq_return = 0, men_restore = 0, men_save;
    logic [2:0]  nmi_req = '0;
    logic [31:0] mask_req = '0;
    logic        req_valid;
    logic [4:0]  req_idx;

    int unsigned n_chk = 0, n_bad = 0;
    logic        m_men = 0;
    logic [31:0] m_ef = '0;

    always #2.5 clk = ~clk;

    intr_enable_unit dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata), .men_set(men_set),
        .men_clr(men_clr), .irq_accept(irq_accept), .irq_return(irq_return),
        .men_restore(men_restore), .men_save(men_save), .nmi_req(nmi_req),
        .mask_req(mask_req), .req_valid(req_valid), .req_idx(req_idx)
    );

    function automatic logic [7:0] exp_read(input logic [7:0] a);
        logic [31:0] full;
        logic [7:0]  off;
        full    = m_ef;
        full[0] = m_men;
        off     = a - 8'h3A;
        if (off < 8'd4) return full[8*off +: 8];
        return 8'h00;
    endfunction

    function automatic logic exp_valid(input logic [2:0] nr, input logic [31:0] mr);
        return (|nr) || (m_men && |(mr & m_ef));
    endfunction

    function automatic logic [4:0] exp_idx(input logic [2:0] nr, input logic [31:0] mr);
        for (int i = 0; i < 3; i++) if (nr[i]) return 5'(i);
        for (int j = 0; j < 32; j++) if (m_men && mr[j] && m_ef[j]) return 5'(j);
        return 5'd0;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc(input logic [7:0] a, input logic [7:0] wd, input logic we,
                       input logic st, input logic cl, input logic acc,
                       input logic rt, input logic rs, input logic [2:0] nr,
                       input logic [31:0] mr, input string tag);
        logic [7:0] off;
        @(negedge clk);
        reg_addr = a; reg_wdata = wd; reg_we = we; men_set = st; men_clr = cl;
        irq_accept = acc; irq_return = rt; men_restore = rs;
        nmi_req = nr; mask_req = mr;
        #1;
        check(tag, 32'(reg_rdata), 32'(exp_read(a)));
        check((|nr) ? "R3" : "R2", 32'(req_valid), 32'(exp_valid(nr, mr)));
        if (exp_valid(nr, mr)) check("R4", 32'(req_idx), 32'(exp_idx(nr, mr)));
        check("R5", 32'(men_save), 32'(m_men));
        @(posedge clk);
        off = a - 8'h3A;
        if (we && off < 8'd4) m_ef[8*off +: 8] = wd & IMPL[8*off +: 8];
        if (acc)                    m_men = 1'b0;
        else if (rt)                m_men = rs;
        else if (cl)                m_men = 1'b0;
        else if (st)                m_men = 1'b1;
        else if (we && off == 8'd0) m_men = wd[0];
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        for (int k = 0; k < 4; k++)
            cyc(8'h3A + 8'(k), 8'h00, 0, 0, 0, 0, 0, 0, 3'b000, 32'hFFFF_FFFF, "R1");
        // R9: unimplemented bits
        cyc(8'h3A, 8'hFF, 1, 0, 0, 0, 0, 0, 3'b000, 32'h0, "R9");
        cyc(8'h3A, 8'h00, 0, 0, 0, 0, 0, 0, 3'b000, 32'h0, "R9");
        cyc(8'h3D, 8'hFF, 1, 0, 0, 0, 0, 0, 3'b000, 32'h0, "R9");
        cyc(8'h3D, 8'h00, 0, 0, 0, 0, 0, 0, 3'b000, 32'h0, "R9");
        // R8: out-of-window writes ignored
        cyc(8'h3E, 8'hFF, 1, 0, 0, 0, 0, 0, 3'b000, 32'h0, "R8");
        cyc(8'h3E, 8'h00, 0, 0, 0, 0, 0, 0, 3'b000, 32'h0, "R8");
        cyc(8'h39, 8'hFF, 1, 0, 0, 0, 0, 0, 3'b000, 32'h0, "R8");
        cyc(8'h39, 8'h00, 0, 0, 0, 0, 0, 0, 3'b000, 32'h0, "R8");
        // R2/R4: lowest eligible maskable wins
        cyc(8'h3B, 8'hA0, 1, 0, 0, 0, 0, 0, 3'b000, 32'h0000_2020, "R8");
        cyc(8'h3B, 8'h00, 0, 0, 0, 0, 0, 0, 3'b000, 32'h0000_A000, "R2");
        // R3: NMI with everything else present
        cyc(8'h3A, 8'h00, 0, 0, 0, 0, 0, 0, 3'b110, 32'hFFFF_FFFF, "R3");
        // R10: accept beats a write of bit 0
        cyc(8'h3A, 8'h01, 1, 0, 0, 1, 0, 0, 3'b000, 32'h0, "R10");
        cyc(8'h3A, 8'h00, 0, 0, 0, 0, 0, 0, 3'b000, 32'h0, "R10");
        // R10: set strobe beats write of 0
        cyc(8'h3A, 8'h00, 1, 1, 0, 0, 0, 0, 3'b000, 32'h0, "R10");
        cyc(8'h3A, 8'h00, 0, 0, 0, 0, 0, 0, 3'b000, 32'h0, "R10");
        // R7: clear wins over set
        cyc(8'h3A, 8'h00, 0, 1, 1, 0, 0, 0, 3'b000, 32'h0, "R7");
        cyc(8'h3A, 8'h00, 0, 0, 0, 0, 0, 0, 3'b000, 32'h0, "R7");
        // R6: return restores, beating a clear strobe
        cyc(8'h3A, 8'h00, 0, 0, 1, 0, 1, 1, 3'b000, 32'h0, "R6");
        cyc(8'h3A, 8'h00, 0, 0, 0, 0, 0, 0, 3'b000, 32'h0000_0020, "R6");

        for (int i = 0; i < 4000; i++) begin
            logic [7:0] a;
            a = 8'h39 + 8'($urandom % 6);
            cyc(a, 8'($urandom), ($urandom % 3) == 0,
                ($urandom % 6) == 0, ($urandom % 8) == 0,
                ($urandom % 10) == 0, ($urandom % 10) == 0, 1'($urandom),
                (($urandom % 4) == 0) ? 3'($urandom) : 3'b000,
                $urandom & $urandom, "R8");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule